// File: doc/BRIEF.md
# Nine-Bit Asynchronous Receiver with Address Filtering

This block receives asynchronous serial characters of eight or nine data bits and stores them in a two-entry buffer for the host to collect. An oversampling tick drives a frame engine that watches for a falling edge on the line, confirms the start bit half a bit later, and then samples every data bit and the stop bit at its centre. A character is sent least significant bit first. In nine-bit mode the extra bit follows data bit 7.

In a multidrop network the host turns on address filtering. While filtering is on and nine-bit mode is on, a character whose ninth bit is clear never reaches the buffer. A character whose ninth bit is set is stored and raises the data-available flag. Each stored character keeps its own stop-bit error. A character that completes while both buffer entries are occupied latches an overrun flag. That flag holds off further stores until the host drops the receive enable.

Top module: `sercv_addr_rx`

## Requirements
- R1: After reset, `rx_irq`, `ovr_err` and `frm_err` are all low.
- R2: In eight-bit mode (`mode9`=0) a frame is one low start bit, eight data bits LSB first and one stop bit. The byte appears on `rd_data` and `rd_bit9` reads 0.
- R3: In nine-bit mode (`mode9`=1) the bit that follows data bit 7 is reported on `rd_bit9` together with its byte.
- R4: With `addr_det`=1 and `mode9`=1, a character whose ninth bit is 0 is discarded and does not raise `rx_irq`. A character whose ninth bit is 1 is stored.
- R5: With `mode9`=0, every character is stored whatever the value of `addr_det`.
- R6: A stop bit sampled low sets `frm_err` while that character is at the head of the buffer. The next character received with a high stop bit shows `frm_err`=0.
- R7: The buffer holds two characters in arrival order. `rx_irq` stays high while at least one is unread, and each one-cycle `rd_stb` removes the head entry.
- R8: A character that completes while both entries are full sets `ovr_err`. That character is dropped and the two stored entries are kept.
- R9: While `ovr_err` is high no character is stored. Only `rx_en`=0 clears `ovr_err`.
- R10: While `rx_en`=0 the receiver stays idle and a character on the line is ignored.
- R11: A low pulse that ends before the half-bit start check is not taken as a character.
- R12: `fast_sel`=1 gives 16 oversampling ticks per bit and `fast_sel`=0 gives 64. The tick period is `TICK_DIV` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Continuous receive enable; low clears overrun |
| mode9 | input | 1 | 1 = nine data bits per character |
| addr_det | input | 1 | 1 = keep only characters with ninth bit set (nine-bit mode) |
| fast_sel | input | 1 | 1 = 16 ticks per bit, 0 = 64 ticks per bit |
| rd_stb | input | 1 | One-cycle read of the head entry |
| rd_data | output | 8 | Head entry data byte |
| rd_bit9 | output | 1 | Head entry ninth bit |
| rx_irq | output | 1 | High while an unread character is buffered |
| frm_err | output | 1 | Stop-bit error of the head entry |
| ovr_err | output | 1 | Sticky overrun flag |

## Verification
A wrong bit counter or sample phase corrupts the byte or ninth bit of the next character. This shows on `rd_data` or `rd_bit9` the first time that entry is read, about one character time after the stimulus. A buffer pointer or count error shows as reordered, duplicated or missing characters, or as `rx_irq` held high or dropped early within one read. A bad overrun or filter decision shows as a character that is stored when it should not be, or lost. The scoreboard reports it as unexpected or missing data at the next drain.

// File: rtl/sercv_pkg.sv
package sercv_pkg;
   localparam int CHAR_W = 8;

   typedef struct packed {
      logic              ferr;
      logic              b9;
      logic [CHAR_W-1:0] data;
   } sercv_ent_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } sercv_st_t;
endpackage

// File: rtl/sercv_tick.sv
module sercv_tick #(
   parameter int TICK_DIV = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

   generate
      if (TICK_DIV < 1) begin : g_bad
         $error("TICK_DIV must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == LAST);
endmodule

// File: rtl/sercv_frame.sv
module sercv_frame
   import sercv_pkg::*;
#(
   parameter int OSR_FAST    = 16,
   parameter int OSR_SLOW    = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       rxd,
   input  logic       mode9,
   input  logic       fast_sel,
   input  logic       tick,
   output logic       done,
   output sercv_ent_t ent
);
   localparam int OSR_MAX = (OSR_SLOW > OSR_FAST) ? OSR_SLOW : OSR_FAST;
   localparam int CW      = $clog2(OSR_MAX);
   localparam logic [CW-1:0] FAST_LAST = CW'(OSR_FAST - 1);
   localparam logic [CW-1:0] SLOW_LAST = CW'(OSR_SLOW - 1);
   localparam logic [CW-1:0] FAST_HALF = CW'(OSR_FAST / 2 - 1);
   localparam logic [CW-1:0] SLOW_HALF = CW'(OSR_SLOW / 2 - 1);

   generate
      if (OSR_FAST < 4 || OSR_SLOW < 4) begin : g_bad_osr
         $error("oversampling ratios must be at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   // input synchronizer chain, reset to line-idle level
   logic [SYNC_STAGES-1:0] sync_q;
   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b1;
               else        sync_q[0] <= rxd;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[gi] <= 1'b1;
               else        sync_q[gi] <= sync_q[gi-1];
            end
         end
      end
   endgenerate

   logic rx_s;
   assign rx_s = sync_q[SYNC_STAGES-1];

   sercv_st_t     st;
   logic          rx_q;
   logic [CW-1:0] cnt;
   logic [3:0]    bidx;
   logic [8:0]    shreg;
   logic          ferr_q;
   logic [CW-1:0] bit_last;
   logic [CW-1:0] half_last;
   logic [3:0]    idx_last;

   assign bit_last  = fast_sel ? FAST_LAST : SLOW_LAST;
   assign half_last = fast_sel ? FAST_HALF : SLOW_HALF;
   assign idx_last  = mode9 ? 4'd8 : 4'd7;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         rx_q   <= 1'b1;
         cnt    <= '0;
         bidx   <= '0;
         shreg  <= '0;
         ferr_q <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         rx_q <= rx_s;
         if (!en) begin
            st  <= ST_IDLE;
            cnt <= '0;
         end else begin
            case (st)
               ST_IDLE: begin
                  if (!rx_s && rx_q) begin
                     st  <= ST_START;
                     cnt <= '0;
                  end
               end
               ST_START: begin
                  if (tick) begin
                     if (cnt == half_last) begin
                        cnt <= '0;
                        if (!rx_s) begin
                           st   <= ST_DATA;
                           bidx <= '0;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               ST_DATA: begin
                  if (tick) begin
                     if (cnt == bit_last) begin
                        cnt         <= '0;
                        shreg[bidx] <= rx_s;
                        if (bidx == idx_last) st   <= ST_STOP;
                        else                  bidx <= bidx + 1'b1;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               ST_STOP: begin
                  if (tick) begin
                     if (cnt == bit_last) begin
                        cnt    <= '0;
                        ferr_q <= !rx_s;
                        done   <= 1'b1;
                        st     <= ST_IDLE;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   assign ent.data = shreg[7:0];
   assign ent.b9   = mode9 & shreg[8];
   assign ent.ferr = ferr_q;
endmodule

// File: rtl/sercv_fifo.sv
module sercv_fifo
   import sercv_pkg::*;
#(
   parameter int DEPTH = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       push,
   input  sercv_ent_t din,
   input  logic       pop,
   output sercv_ent_t dout,
   output logic       empty,
   output logic       full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int NW = $clog2(DEPTH + 1);
   localparam logic [NW-1:0] NFULL = NW'(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
   endgenerate

   sercv_ent_t    mem [DEPTH];
   logic [PW-1:0] wp;
   logic [PW-1:0] rp;
   logic [NW-1:0] used;
   logic          do_push;
   logic          do_pop;

   assign empty   = (used == '0);
   assign full    = (used == NFULL);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp   <= '0;
         rp   <= '0;
         used <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   used <= used + 1'b1;
            2'b01:   used <= used - 1'b1;
            default: used <= used;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   assign dout = mem[rp];
endmodule

// File: rtl/sercv_addr_rx.sv
module sercv_addr_rx
   import sercv_pkg::*;
#(
   parameter int TICK_DIV    = 1,
   parameter int OSR_FAST    = 16,
   parameter int OSR_SLOW    = 64,
   parameter int SYNC_STAGES = 2,
   parameter int DEPTH       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd,
   input  logic              rx_en,
   input  logic              mode9,
   input  logic              addr_det,
   input  logic              fast_sel,
   input  logic              rd_stb,
   output logic [CHAR_W-1:0] rd_data,
   output logic              rd_bit9,
   output logic              rx_irq,
   output logic              frm_err,
   output logic              ovr_err
);
   logic       tick;
   logic       done;
   sercv_ent_t ent;
   sercv_ent_t head;
   logic       empty;
   logic       full;
   logic       keep;
   logic       push;

   sercv_tick #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (rx_en),
      .tick (tick)
   );

   sercv_frame #(
      .OSR_FAST   (OSR_FAST),
      .OSR_SLOW   (OSR_SLOW),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (rx_en),
      .rxd     (rxd),
      .mode9   (mode9),
      .fast_sel(fast_sel),
      .tick    (tick),
      .done    (done),
      .ent     (ent)
   );

   // address filter: only active with nine-bit framing
   assign keep = !(mode9 && addr_det && !ent.b9);
   assign push = done && rx_en && !ovr_err && !full && keep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ovr_err <= 1'b0;
      else if (!rx_en)                     ovr_err <= 1'b0;
      else if (done && full && !ovr_err)   ovr_err <= 1'b1;
   end

   sercv_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .push (push),
      .din  (ent),
      .pop  (rd_stb),
      .dout (head),
      .empty(empty),
      .full (full)
   );

   assign rx_irq  = !empty;
   assign rd_data = head.data;
   assign rd_bit9 = head.b9;
   assign frm_err = !empty && head.ferr;
endmodule

// File: rtl/sercv_addr_rx_chk.sv
module sercv_addr_rx_chk (
   input logic clk,
   input logic rst_n,
   input logic rx_en,
   input logic rd_stb,
   input logic rx_irq,
   input logic ovr_err
);
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_err && rx_en) |=> ovr_err);                              // R9
   AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !ovr_err);                                         // R9
   AST_OVR_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_err) |-> $past(rx_irq));                            // R8
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_irq && !rd_stb) |=> rx_irq);                              // R7
   AST_IRQ_DROP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_irq) |-> $past(rd_stb));                             // R7
   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_irq) |-> $past(rx_en));                              // R10
endmodule

bind sercv_addr_rx sercv_addr_rx_chk u_chk (.*);

// File: tb/sercv_addr_rx_test.sv
`timescale 1ns/1ps
module sercv_addr_rx_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic       rx_en = 1'b1;
   logic       mode9 = 1'b0;
   logic       addr_det = 1'b0;
   logic       fast_sel = 1'b1;
   logic       rd_stb = 1'b0;
   logic [7:0] rd_data;
   logic       rd_bit9;
   logic       rx_irq;
   logic       frm_err;
   logic       ovr_err;

   int total = 0;
   int bad = 0;
   bit auto_rd = 1'b0;
   bit finished = 1'b0;

   logic [9:0] exp_q [$];
   string      tag_q [$];

   always #2.5 clk = ~clk;

   sercv_addr_rx uut (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_en(rx_en), .mode9(mode9),
      .addr_det(addr_det), .fast_sel(fast_sel), .rd_stb(rd_stb),
      .rd_data(rd_data), .rd_bit9(rd_bit9), .rx_irq(rx_irq),
      .frm_err(frm_err), .ovr_err(ovr_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_char(input logic [7:0] d, input logic b9, input logic fe, input string tag);
      exp_q.push_back({fe, b9, d});
      tag_q.push_back(tag);
   endtask

   task automatic send(input logic [7:0] d, input logic b9, input logic stopv);
      int p;
      p = fast_sel ? 16 : 64;
      rxd = 1'b0; hold(p);
      for (int i = 0; i < 8; i++) begin
         rxd = d[i]; hold(p);
      end
      if (mode9) begin
         rxd = b9; hold(p);
      end
      rxd = stopv; hold(p);
      rxd = 1'b1; hold(p);
   endtask

   task automatic drain(input string tag);
      auto_rd = 1'b1;
      hold(20);
      chk({tag, " pending"}, exp_q.size(), 0);
      exp_q.delete();
      tag_q.delete();
   endtask

   // scoreboard monitor: reads and compares whenever allowed
   initial begin
      forever begin
         @(negedge clk);
         if (rd_stb) begin
            rd_stb = 1'b0;
         end else if (auto_rd && rx_irq) begin
            if (exp_q.size() == 0) begin
               total++; bad++;
               $display("FAIL unexpected character actual=%0h expected=none",
                        {frm_err, rd_bit9, rd_data});
            end else begin
               logic [9:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(t, {22'd0, frm_err, rd_bit9, rd_data}, {22'd0, e});
            end
            rd_stb = 1'b1;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      hold(5);
      rst_n = 1'b1;
      hold(2);
      chk("R1 irq", rx_irq, 0);
      chk("R1 ovr", ovr_err, 0);
      chk("R1 frm", frm_err, 0);
      auto_rd = 1'b1;

      // R2 eight-bit characters
      expect_char(8'h55, 0, 0, "R2 55"); send(8'h55, 0, 1);
      expect_char(8'hA3, 0, 0, "R2 A3"); send(8'hA3, 0, 1);
      expect_char(8'h00, 0, 0, "R2 00"); send(8'h00, 0, 1);
      expect_char(8'hFF, 0, 0, "R2 FF"); send(8'hFF, 0, 1);
      drain("R2");

      // R3 nine-bit, no filter
      mode9 = 1'b1;
      expect_char(8'h3C, 1, 0, "R3 b9=1"); send(8'h3C, 1, 1);
      expect_char(8'hC3, 0, 0, "R3 b9=0"); send(8'hC3, 0, 1);
      drain("R3");

      // R4 address filter
      addr_det = 1'b1;
      send(8'h12, 0, 1);
      chk("R4 data discarded", rx_irq, 0);
      expect_char(8'h9A, 1, 0, "R4 address kept"); send(8'h9A, 1, 1);
      drain("R4");

      // R5 filter inactive in eight-bit mode
      mode9 = 1'b0;
      expect_char(8'h47, 0, 0, "R5"); send(8'h47, 0, 1);
      drain("R5");
      addr_det = 1'b0;

      // R6 framing error travels with its character
      expect_char(8'h5A, 0, 1, "R6 bad stop"); send(8'h5A, 0, 0);
      expect_char(8'h66, 0, 0, "R6 next clean"); send(8'h66, 0, 1);
      drain("R6");

      // R7 two entries kept in order
      auto_rd = 1'b0;
      send(8'h11, 0, 1);
      send(8'h22, 0, 1);
      chk("R7 irq while unread", rx_irq, 1);
      chk("R7 no overrun", ovr_err, 0);
      expect_char(8'h11, 0, 0, "R7 first"); expect_char(8'h22, 0, 0, "R7 second");
      drain("R7");
      chk("R7 irq after reads", rx_irq, 0);

      // R8 overrun
      auto_rd = 1'b0;
      send(8'h31, 0, 1);
      send(8'h32, 0, 1);
      send(8'h33, 0, 1);
      chk("R8 overrun set", ovr_err, 1);
      expect_char(8'h31, 0, 0, "R8 kept1"); expect_char(8'h32, 0, 0, "R8 kept2");
      drain("R8");

      // R9 no stores while overrun, cleared by enable low
      send(8'h34, 0, 1);
      chk("R9 blocked", rx_irq, 0);
      chk("R9 still set", ovr_err, 1);
      rx_en = 1'b0; hold(4);
      chk("R9 cleared", ovr_err, 0);
      rx_en = 1'b1; hold(2);
      expect_char(8'h35, 0, 0, "R9 resumed"); send(8'h35, 0, 1);
      drain("R9");

      // R10 disabled receiver
      rx_en = 1'b0;
      send(8'h77, 0, 1);
      chk("R10 ignored", rx_irq, 0);
      rx_en = 1'b1; hold(2);
      expect_char(8'h78, 0, 0, "R10 after enable"); send(8'h78, 0, 1);
      drain("R10");

      // R11 short glitch
      rxd = 1'b0; hold(3); rxd = 1'b1; hold(40);
      chk("R11 glitch", rx_irq, 0);
      expect_char(8'h79, 0, 0, "R11 after glitch"); send(8'h79, 0, 1);
      drain("R11");

      // R12 slow rate
      fast_sel = 1'b0;
      expect_char(8'hA5, 0, 0, "R12 slow"); send(8'hA5, 0, 1);
      mode9 = 1'b1;
      expect_char(8'h0F, 1, 0, "R12 slow nine-bit"); send(8'h0F, 1, 1);
      drain("R12");

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule